// File: doc/BRIEF.md
# Iterative Vector Angle and Magnitude Unit

This block converts a signed Cartesian pair (an I and a Q sample) into a polar result. It returns the angle over a full turn and a magnitude that is scaled by the fixed rotation gain. It uses only shifts, adds and a small table of arctangent constants, so it needs no multiplier. A request is issued with a one-cycle `start` pulse. The unit then works on that vector alone for a fixed number of cycles and announces the result with a one-cycle `done` strobe.

Inside, the vector is first moved into the right half-plane. When I is negative, it is turned by a quarter turn in the direction that brings it closest to the positive I axis, and the angle accumulator is preset to ±90°. After that, one micro-rotation runs per clock. Each micro-rotation looks at the sign of Q and turns the vector toward the I axis, while the accumulator adds or subtracts the matching arctangent constant. When the last step is done, the accumulator holds the angle and I holds the scaled length.

Top module: `cordic_atan2`

## Requirements
- R1: While reset is held, and after it is released, `done` and `busy` are 0 and `phase_out` and `mag_out` read 0.
- R2: A `start` sampled while `busy` is 0 raises `busy` on the next cycle. `done` is high for exactly one cycle, N+1 clock edges after the edge that accepted `start` (N = 14 iterations). `busy` falls on that same edge.
- R3: A `start` pulse that arrives while `busy` is 1 is ignored. The result that follows belongs to the vector that was accepted first, and no extra `done` strobe appears.
- R4: For I ≥ 0, `phase_out` equals atan2(Q, I) to within 16 LSB. `phase_out` is a signed 16-bit value in which 2^16 counts one full turn, so +90° reads 16384 and ±180° reads -32768.
- R5: For I < 0 and Q ≥ 0, the vector is turned by -90° before the iterations and the angle accumulator starts at +90°. `phase_out` then falls between +90° and +180° (with +180° reading -32768) and matches atan2 within 16 LSB.
- R6: For I < 0 and Q < 0, the vector is turned by +90° and the accumulator starts at -90°. `phase_out` lies in the third quadrant and matches atan2 within 16 LSB.
- R7: `mag_out` is an unsigned 18-bit value. It equals K·sqrt(I²+Q²) within 24 LSB, where K is the product of sqrt(1+2^-2k) for k = 0..N-1 (about 1.647). It does not overflow, even for full-scale corner inputs.
- R8: `phase_out` and `mag_out` change only on the edge that raises `done`, and they hold their values until the next result.
- R9: Vectors that lie on an axis (0°, +90°, -90°, 180°) produce their exact angle to within the R4 tolerance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken only while idle |
| in_i | input | 16 | Signed I component |
| in_q | input | 16 | Signed Q component |
| busy | output | 1 | High from the accept edge until the result edge |
| done | output | 1 | One-cycle result strobe |
| phase_out | output | 16 | Signed angle, 2^16 LSB per full turn |
| mag_out | output | 18 | Unsigned magnitude scaled by the gain K |

## Verification
The result for an accepted vector is due exactly N+1 = 15 edges after the accepting edge: one edge loads the pre-rotated vector, fourteen edges perform the micro-rotations, and one edge publishes the result. The driver records the cycle number at which it presents each request. The monitor samples on falling edges and compares the cycle at which each strobe appears against that recorded cycle plus the load-and-iterate span. It then compares the angle and magnitude with values computed in real arithmetic. Requests that are refused while the unit is busy are never queued, so an unexpected strobe shows up as an empty-queue failure.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    localparam int DW = 16;              // input sample width
    localparam int GUARD = 2;            // headroom for the gain growth
    localparam int IW = DW + GUARD;      // internal I/Q width
    localparam int PW = 16;              // angle width, 2^PW = one turn
    localparam int N_ITER = 14;          // micro-rotations per request
    localparam int CW = (N_ITER > 1) ? $clog2(N_ITER) : 1;

    localparam logic signed [PW-1:0] QUARTER_TURN = PW'(1 << (PW - 2));

    typedef struct packed {
        logic signed [IW-1:0] x;
        logic signed [IW-1:0] y;
        logic signed [PW-1:0] z;
    } rot_vec_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } ctl_state_t;

    // arctangent of 2^-k expressed in turns * 2^PW, rounded
    function automatic logic [PW-1:0] atan_step(input int k);
        real ang;
        ang = $atan(2.0 ** (-k)) / (2.0 * 3.14159265358979323846) * (2.0 ** PW);
        return PW'($rtoi(ang + 0.5));
    endfunction

endpackage

// File: rtl/cordic_prerot.sv
module cordic_prerot
    import cordic_pkg::*;
(
    input  logic signed [DW-1:0] src_i,
    input  logic signed [DW-1:0] src_q,
    output rot_vec_t             vec
);
    logic signed [IW-1:0] xi;
    logic signed [IW-1:0] yq;

    assign xi = IW'(src_i);
    assign yq = IW'(src_q);

    always_comb begin
        if (!xi[IW-1]) begin
            vec.x = xi;
            vec.y = yq;
            vec.z = '0;
        end else if (!yq[IW-1]) begin
            // second quadrant: turn by -90 degrees
            vec.x = yq;
            vec.y = -xi;
            vec.z = QUARTER_TURN;
        end else begin
            // third quadrant: turn by +90 degrees
            vec.x = -yq;
            vec.y = xi;
            vec.z = -QUARTER_TURN;
        end
    end
endmodule

// File: rtl/cordic_atan_rom.sv
module cordic_atan_rom
    import cordic_pkg::*;
(
    input  logic [CW-1:0]     idx,
    output logic signed [PW-1:0] angle
);
    logic [PW-1:0] tbl [N_ITER];

    for (genvar k = 0; k < N_ITER; k++) begin : g_tbl
        assign tbl[k] = atan_step(k);
    end

    always_comb begin
        angle = '0;
        for (int k = 0; k < N_ITER; k++) begin
            if (idx == CW'(k)) angle = tbl[k];
        end
    end
endmodule

// File: rtl/cordic_micro_rot.sv
module cordic_micro_rot
    import cordic_pkg::*;
(
    input  rot_vec_t             cur,
    input  logic [CW-1:0]        shift,
    input  logic signed [PW-1:0] step_ang,
    output rot_vec_t             nxt
);
    logic signed [IW-1:0] xs;
    logic signed [IW-1:0] ys;

    assign xs = cur.x >>> shift;
    assign ys = cur.y >>> shift;

    always_comb begin
        if (!cur.y[IW-1]) begin
            nxt.x = cur.x + ys;
            nxt.y = cur.y - xs;
            nxt.z = cur.z + step_ang;
        end else begin
            nxt.x = cur.x - ys;
            nxt.y = cur.y + xs;
            nxt.z = cur.z - step_ang;
        end
    end
endmodule

// File: rtl/cordic_atan2.sv
module cordic_atan2
    import cordic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    output logic                 busy,
    output logic                 done,
    output logic signed [PW-1:0] phase_out,
    output logic [IW-1:0]        mag_out
);
    ctl_state_t           state;
    logic [CW-1:0]        step;
    rot_vec_t             work;
    rot_vec_t             loaded;
    rot_vec_t             rotated;
    logic signed [PW-1:0] step_ang;

    cordic_prerot u_pre (
        .src_i (in_i),
        .src_q (in_q),
        .vec   (loaded)
    );

    cordic_atan_rom u_rom (
        .idx   (step),
        .angle (step_ang)
    );

    cordic_micro_rot u_rot (
        .cur      (work),
        .shift    (step),
        .step_ang (step_ang),
        .nxt      (rotated)
    );

    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            step      <= '0;
            work      <= '0;
            done      <= 1'b0;
            phase_out <= '0;
            mag_out   <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        work  <= loaded;
                        step  <= '0;
                        state <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    work <= rotated;
                    if (step == CW'(N_ITER - 1)) begin
                        state <= ST_FIN;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                ST_FIN: begin
                    phase_out <= work.z;
                    mag_out   <= $unsigned(work.x);
                    done      <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cordic_atan2_chk.sv
module cordic_atan2_chk
    import cordic_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic signed [PW-1:0] phase_out,
    input logic [IW-1:0]        mag_out
);
    localparam int LAT = N_ITER + 1;
    localparam int LW = $clog2(LAT + 2);

    logic [LW-1:0] since_go;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_go <= LW'(LAT + 1);
        end else if (start && !busy) begin
            since_go <= '0;
        end else if (since_go != LW'(LAT + 1)) begin
            since_go <= since_go + 1'b1;
        end
    end

    // R1: quiet outputs after reset
    a_r1_idle_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (!busy && !done));

    // R2: single-cycle strobe
    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2, R3: strobe lands N+1 edges after the accepted request only
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (since_go == LW'(LAT)));

    // R2: busy rises only after a request
    a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R2: busy falls together with the strobe
    a_r2_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R8: results held between strobes
    a_r8_hold_phase: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(phase_out));

    a_r8_hold_mag: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(mag_out));

    // R7: magnitude never shows a wrapped (top-bit) value
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        done |-> !mag_out[IW-1]);
endmodule

bind cordic_atan2 cordic_atan2_chk u_chk (.*);

// File: tb/cordic_atan2_test.sv
module cordic_atan2_test;
    import cordic_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PH_TOL = 16;
    localparam int MAG_TOL = 24;
    localparam real PI = 3.14159265358979323846;

    typedef struct {
        int    vi;
        int    vq;
        int    cyc;
        string tag;
    } exp_t;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start = 1'b0;
    logic signed [DW-1:0] in_i = '0;
    logic signed [DW-1:0] in_q = '0;
    logic                 busy;
    logic                 done;
    logic signed [PW-1:0] phase_out;
    logic [IW-1:0]        mag_out;

    int   n_checks = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   n_done = 0;
    exp_t sb[$];
    real  gain_k;

    cordic_atan2 uut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .in_i      (in_i),
        .in_q      (in_q),
        .busy      (busy),
        .done      (done),
        .phase_out (phase_out),
        .mag_out   (mag_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // driver: present one request at a falling edge and queue its expectation
    task automatic drive_vec(input int vi, input int vq, input string tag);
        exp_t e;
        while (busy) @(negedge clk);
        in_i  = DW'(vi);
        in_q  = DW'(vq);
        start = 1'b1;
        e.vi = vi; e.vq = vq; e.cyc = cyc; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
    endtask

    // monitor: compare each strobe with the oldest queued expectation
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && done) begin
                n_done++;
                if (sb.size() == 0) begin
                    check(1'b0, "R3 unexpected strobe", 1, 0);
                end else begin
                    exp_t e;
                    real  ang;
                    int   exp_ph;
                    int   dph;
                    int   exp_mag;
                    int   act_ph;
                    e = sb.pop_front();
                    check(cyc == e.cyc + N_ITER + 2, "R2 latency", cyc - e.cyc, N_ITER + 2);
                    ang = $atan2(real'(e.vq), real'(e.vi));
                    exp_ph = $rtoi($floor(ang / (2.0 * PI) * (2.0 ** PW) + 0.5));
                    act_ph = int'(phase_out);
                    dph = act_ph - exp_ph;
                    while (dph > (1 << (PW - 1))) dph -= (1 << PW);
                    while (dph < -(1 << (PW - 1))) dph += (1 << PW);
                    check(dph <= PH_TOL && dph >= -PH_TOL, e.tag, act_ph, exp_ph);
                    exp_mag = $rtoi(gain_k * $sqrt(real'(e.vi) * e.vi + real'(e.vq) * e.vq) + 0.5);
                    check((int'(mag_out) - exp_mag <= MAG_TOL) && (exp_mag - int'(mag_out) <= MAG_TOL),
                          "R7 magnitude", int'(mag_out), exp_mag);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic signed [PW-1:0] held_ph;
        logic [IW-1:0]        held_mag;
        int                   d0;

        gain_k = 1.0;
        for (int k = 0; k < N_ITER; k++) gain_k = gain_k * $sqrt(1.0 + 2.0 ** (-2 * k));

        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        check(!busy && !done, "R1 flags in reset", {busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(phase_out == 0 && mag_out == 0, "R1 outputs after reset", int'(mag_out), 0);
        check(!busy && !done, "R1 flags after reset", {busy, done}, 0);

        // R2: busy rises right after the accepting edge
        drive_vec(20000, 5000, "R4 first quadrant");
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        drive_vec(20000, -15000, "R4 fourth quadrant");
        drive_vec(30000, 0, "R9 zero degrees");
        drive_vec(0, 25000, "R9 plus ninety");
        drive_vec(0, -25000, "R9 minus ninety");
        drive_vec(-25000, 0, "R9 one eighty");
        drive_vec(-18000, 12000, "R5 second quadrant");
        drive_vec(-32768, 32767, "R5 full-scale corner");
        drive_vec(-10000, -22000, "R6 third quadrant");
        drive_vec(-32768, -32768, "R6 full-scale corner");
        drive_vec(32767, 32767, "R4 diagonal full scale");

        // R3: a second request while busy must be dropped
        drive_vec(15000, 15000, "R3 first request kept");
        repeat (3) @(negedge clk);
        in_i  = DW'(-20000);
        in_q  = DW'(-3000);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        repeat (N_ITER + 4) @(negedge clk);
        check(sb.size() == 0, "R3 queue drained", sb.size(), 0);

        // R8: outputs hold after the strobe
        held_ph  = phase_out;
        held_mag = mag_out;
        d0 = n_done;
        in_i = DW'(123);
        in_q = DW'(-456);
        repeat (5) @(negedge clk);
        check(phase_out == held_ph && mag_out == held_mag && n_done == d0,
              "R8 results held", int'(phase_out), int'(held_ph));

        drive_vec(-3000, 28000, "R5 near ninety from left");
        while (busy || sb.size() != 0) @(negedge clk);
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule